// File: doc/BRIEF.md
# SCL Rate Generator with Divider Decode

This block takes an 8-bit rate code and a filter sampling rate value and turns them into the number of module-clock cycles in one full SCL period. That count sets the pace of a free-running timebase. The divider is not a plain reload value. It is the product of a power-of-two scale and an offset term. The offset term grows when the filter sampling rate is large compared with the scale, so the filter always has room to settle inside a bus phase.

From the active divider the block produces two strobes. The phase strobe marks each half period of SCL and is meant to toggle the clock line in a controller. The sample strobe paces the input glitch filter. The decoded divider is also brought out, so the surrounding logic can see which setting is live.

Settings are taken directly while the block is disabled. While it runs, a new setting is applied only at the end of the current SCL phase, so no shortened phase appears on the bus.

Top module: `scl_rate_gen`

## Requirements
- R1: The scale is B = 16 << rate_code[4:2], giving 16 to 2048. The offset A is selected by the 3-bit value {rate_code[5], rate_code[1:0]}: 0→18, 1→20, 2→24, 3→30, 4→10, 5→12, 6→14, 7→16.
- R2: With D as the effective filter rate, the divider output equals B * (A + 2 * floor(3 * D / B)).
- R3: A filt_rate of zero is treated as a filter rate of 1, both in the divider formula and in the sample strobe period.
- R4: rate_code[7:6] has no effect on the divider or on either strobe.
- R5: While rst_n is low, divider reads 3072, which is the fallback code 0x31 with a filter rate of 1, and both strobes are low.
- R6: While enable is high, phase_tick is a one-cycle pulse every divider/2 clock cycles. The first pulse comes divider/2 cycles after enable is first sampled high.
- R7: While enable is low, both counters are held at zero and neither strobe fires. The divider output follows the inputs one clock after they are sampled.
- R8: A setting changed while enable is high does not affect the current phase. It is applied at the next phase wrap, and divider changes in the same cycle that phase_tick is high.
- R9: While enable is high, sample_tick is a one-cycle pulse (level high when D is 1) every D cycles, counted from the cycle enable is first sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the timebase; low holds the counters and loads settings directly |
| rate_code | input | 8 | Scale and offset selection code |
| filt_rate | input | FILT_W | Filter sampling rate, zero treated as 1 |
| divider | output | 16 | Active SCL period in module-clock cycles |
| phase_tick | output | 1 | One-cycle strobe at each SCL half period |
| sample_tick | output | 1 | Filter sample strobe |

## Verification
Both strobes run from the same enable edge, so the phase strobe and the sample strobe fall on the same cycle whenever the half period is a multiple of the filter rate. Settings such as a rate of 1, or a half period of 96 with a rate of 8, force this overlap. At the first phase strobe the bench checks that the sample strobe is high exactly when that divisibility holds. A second overlap is between a setting change and a phase wrap. The bench changes the code in the middle of a phase. It then checks that the old period completes, and that the new divider appears in the very cycle of the wrapping phase strobe.

// File: rtl/scl_rate_pkg.sv
package scl_rate_pkg;

  localparam int DIV_W = 16;
  localparam logic [7:0] FALLBACK_CODE = 8'h31;

  // offset term chosen by {code[5], code[1:0]}
  function automatic logic [7:0] offset_term(input logic [2:0] sel);
    logic [7:0] a;
    case (sel)
      3'd0: a = 8'd18;
      3'd1: a = 8'd20;
      3'd2: a = 8'd24;
      3'd3: a = 8'd30;
      3'd4: a = 8'd10;
      3'd5: a = 8'd12;
      3'd6: a = 8'd14;
      default: a = 8'd16;
    endcase
    return a;
  endfunction

  // full-period divider; the scale is a power of two, so shifts replace multiply/divide
  function automatic logic [31:0] div_calc(input logic [7:0] code, input logic [31:0] rate);
    logic [4:0]  sh;
    logic [31:0] eff;
    logic [31:0] quo;
    logic [31:0] sum;
    sh  = {2'b00, code[4:2]} + 5'd4;
    eff = (rate == 32'd0) ? 32'd1 : rate;
    quo = (eff * 32'd3) >> sh;
    sum = {24'd0, offset_term({code[5], code[1:0]})} + (quo << 1);
    return sum << sh;
  endfunction

  localparam logic [DIV_W-1:0] FALLBACK_DIV = DIV_W'(div_calc(FALLBACK_CODE, 32'd1));

endpackage

// File: rtl/scl_rst_sync.sv
module scl_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= stage_d;
  end

  assign rst_core_n = stage_q[1];
endmodule

// File: rtl/scl_code_decode.sv
module scl_code_decode
  import scl_rate_pkg::*;
#(
  parameter int FILT_W = 8
) (
  input  logic [7:0]        code,
  input  logic [FILT_W-1:0] rate,
  output logic [DIV_W-1:0]  div_next,
  output logic [FILT_W-1:0] rate_next
);
  logic [31:0] rate_wide;
  logic [31:0] div_wide;

  generate
    if (FILT_W >= 32) begin : g_wide
      assign rate_wide = rate[31:0];
    end else begin : g_narrow
      assign rate_wide = {{(32-FILT_W){1'b0}}, rate};
    end
  endgenerate

  always_comb begin
    // code[7:6] never reaches the calculation
    div_wide  = div_calc({2'b00, code[5:0]}, rate_wide);
    div_next  = div_wide[DIV_W-1:0];
    rate_next = (rate == '0) ? FILT_W'(1) : rate;
  end
endmodule

// File: rtl/scl_setting_reg.sv
module scl_setting_reg
  import scl_rate_pkg::*;
#(
  parameter int FILT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DIV_W-1:0]  div_in,
  input  logic [FILT_W-1:0] rate_in,
  output logic [DIV_W-1:0]  div_q,
  output logic [FILT_W-1:0] rate_q
);
  logic [DIV_W-1:0]  div_d;
  logic [FILT_W-1:0] rate_d;

  always_comb begin
    div_d  = div_q;
    rate_d = rate_q;
    if (load) begin
      div_d  = div_in;
      rate_d = rate_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= FALLBACK_DIV;
      rate_q <= FILT_W'(1);
    end else begin
      div_q  <= div_d;
      rate_q <= rate_d;
    end
  end
endmodule

// File: rtl/scl_tick_counter.sv
module scl_tick_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [W-1:0] last,
  output logic         wrap,
  output logic         tick
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    // >= keeps the counter safe when the limit shrinks under it
    wrap = run && (cnt_q >= last);
    if (!run)      cnt_d = '0;
    else if (wrap) cnt_d = '0;
    else           cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tick  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      tick  <= wrap;
    end
  end
endmodule

// File: rtl/scl_rate_gen.sv
module scl_rate_gen
  import scl_rate_pkg::*;
#(
  parameter int FILT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [7:0]        rate_code,
  input  logic [FILT_W-1:0] filt_rate,
  output logic [DIV_W-1:0]  divider,
  output logic              phase_tick,
  output logic              sample_tick
);
  logic              rst_core_n;
  logic [DIV_W-1:0]  div_next;
  logic [FILT_W-1:0] rate_next;
  logic [DIV_W-1:0]  div_q;
  logic [FILT_W-1:0] rate_q;
  logic [DIV_W-1:0]  phase_last;
  logic [FILT_W-1:0] sample_last;
  logic              phase_wrap;
  logic              sample_wrap;
  logic              load;

  scl_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_core_n (rst_core_n)
  );

  scl_code_decode #(.FILT_W(FILT_W)) u_dec (
    .code      (rate_code),
    .rate      (filt_rate),
    .div_next  (div_next),
    .rate_next (rate_next)
  );

  always_comb begin
    load        = !enable || phase_wrap;
    phase_last  = {1'b0, div_q[DIV_W-1:1]} - DIV_W'(1);
    sample_last = rate_q - FILT_W'(1);
  end

  scl_setting_reg #(.FILT_W(FILT_W)) u_set (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .load    (load),
    .div_in  (div_next),
    .rate_in (rate_next),
    .div_q   (div_q),
    .rate_q  (rate_q)
  );

  scl_tick_counter #(.W(DIV_W)) u_phase (
    .clk   (clk),
    .rst_n (rst_core_n),
    .run   (enable),
    .last  (phase_last),
    .wrap  (phase_wrap),
    .tick  (phase_tick)
  );

  scl_tick_counter #(.W(FILT_W)) u_sample (
    .clk   (clk),
    .rst_n (rst_core_n),
    .run   (enable),
    .last  (sample_last),
    .wrap  (sample_wrap),
    .tick  (sample_tick)
  );

  assign divider = div_q;
endmodule

// File: rtl/scl_rate_gen_chk.sv
module scl_rate_gen_chk
  import scl_rate_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic [DIV_W-1:0] divider,
  input logic             phase_tick,
  input logic             sample_tick
);
  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!phase_tick && !sample_tick));

  // R6
  phase_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase_tick |=> !phase_tick);

  // R8
  div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enable |=> (phase_tick || $stable(divider)));

  // R6
  tick_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase_tick |-> $past(enable));

  // R2
  always @(posedge clk) begin
    if (rst_n) begin
      div_range_chk: assert (divider >= DIV_W'(160) && !divider[0]);
    end
  end
endmodule

bind scl_rate_gen scl_rate_gen_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .enable      (enable),
  .divider     (divider),
  .phase_tick  (phase_tick),
  .sample_tick (sample_tick)
);

// File: tb/scl_rate_gen_test.sv
module scl_rate_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic [7:0]  rate_code = 8'h31;
  logic [7:0]  filt_rate = 8'd0;
  logic [15:0] divider;
  logic        phase_tick;
  logic        sample_tick;

  int n_checks = 0;
  int n_fails  = 0;

  always #4 clk = ~clk;

  scl_rate_gen uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .rate_code(rate_code),
    .filt_rate(filt_rate), .divider(divider), .phase_tick(phase_tick),
    .sample_tick(sample_tick)
  );

  // {code, filt, expected divider}
  localparam logic [31:0] VEC [10] = '{
    {8'h00, 8'd0,   16'd288},   // R1 R3
    {8'h20, 8'd8,   16'd192},   // R2
    {8'h23, 8'd20,  16'd352},   // R2
    {8'h07, 8'd11,  16'd1024},  // R1 R2
    {8'hC6, 8'd3,   16'd768},   // R4
    {8'h31, 8'd2,   16'd3072},  // R1
    {8'h3F, 8'd255, 16'd32768}, // R1
    {8'h21, 8'd255, 16'd1696},  // R2
    {8'h0C, 8'd200, 16'd3328},  // R2
    {8'h25, 8'd40,  16'd576}    // R2
  };

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_phase(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!phase_tick);
  endtask

  task automatic wait_sample(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!sample_tick);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    int n;
    int half;
    int d;
    repeat (3) @(negedge clk);
    // R5 reset state
    check("R5 divider", int'(divider), 3072);
    check("R5 phase_tick", int'(phase_tick), 0);
    check("R5 sample_tick", int'(sample_tick), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < 10; i++) begin
      enable    = 1'b0;
      rate_code = VEC[i][31:24];
      filt_rate = VEC[i][23:16];
      repeat (3) @(negedge clk);
      check("R1 R2 R7 divider while idle", int'(divider), int'(VEC[i][15:0]));
      half = int'(VEC[i][15:0]) / 2;
      d = (VEC[i][23:16] == 8'd0) ? 1 : int'(VEC[i][23:16]);
      enable = 1'b1;
      wait_phase(n);
      check("R6 first phase latency", n, half);
      check("R9 sample coincides at first phase", int'(sample_tick), ((half % d) == 0) ? 1 : 0);
      wait_phase(n);
      check("R6 phase interval", n, half);
      wait_sample(n);
      wait_sample(n);
      check("R3 R9 sample interval", n, d);
    end

    // R8 mid-phase change
    enable = 1'b0; rate_code = 8'h20; filt_rate = 8'd8;
    repeat (3) @(negedge clk);
    enable = 1'b1;
    wait_phase(n);
    repeat (10) @(negedge clk);
    rate_code = 8'h00;
    @(negedge clk);
    check("R8 divider held mid-phase", int'(divider), 192);
    wait_phase(n);
    check("R8 old phase completes", n, 96 - 11);
    check("R8 divider updates with tick", int'(divider), 320);
    wait_phase(n);
    check("R8 new phase interval", n, 160);

    // R7 idle hold
    enable = 1'b0;
    @(negedge clk);
    n = 0;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      if (phase_tick || sample_tick) n++;
    end
    check("R7 no strobes while idle", n, 0);
    rate_code = 8'hE0; filt_rate = 8'd8;
    @(negedge clk);
    @(negedge clk);
    check("R4 R7 divider follows idle input", int'(divider), 192);
    enable = 1'b1;
    wait_phase(n);
    check("R7 counter restarted", n, 96);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule